// File: doc/BRIEF.md
# Receive Message-Object FIFO Allocator

This block sits between a CAN frame engine and a bank of message objects. When the engine signals that a frame has been accepted, the allocator picks the object that will hold it. Every object is configured by three inputs: valid, receive or transmit, and end-of-buffer. The allocator takes the lowest-numbered valid receive object that does not yet hold unread data. It raises that object's new-data and interrupt-pending flags. It also returns a write strobe, the chosen index and the frame identifier, so that the storage logic can write the payload.

A run of receive objects that ends in one with its end-of-buffer bit set behaves as a FIFO. Once every receive object holds unread data, the next frame overwrites the lowest valid receive object that is marked end-of-buffer, and that object's message-lost flag is set. If no such object exists, the frame is dropped.

The block also keeps a transmit-request vector and the interrupt-pending vector, one bit per object. From the pending bits and a status-interrupt input it builds an interrupt identifier. A host clears flags with per-object clear pulses. The transmit side sets and completes requests with per-object pulses.

Top module: `rxfifo_alloc`

## Requirements
- R1: While reset is held and after it is released, all flag vectors are zero, `wrStrobe` and `wrLost` are low and `intId` is 0.
- R2: An object is free when its `objValid` bit and its `objIsRx` bit are 1 and its new-data bit is 0. A frame presented with `frameValid` high is given to the lowest free object. In the next cycle `wrStrobe` is 1, `wrIndex` holds the bit position of that object (object n at position n-1), `wrId` holds the frame identifier and `wrLost` is 0.
- R3: A stored frame sets both the new-data bit and the interrupt-pending bit at `wrIndex`. No more than one new-data bit rises per cycle.
- R4: If no object is free, the frame overwrites the lowest valid receive object whose `objEob` bit is 1. That object gets new-data, interrupt-pending and message-lost set, and `wrLost` is 1 together with `wrStrobe`.
- R5: If no object is free and no valid receive object has `objEob` set, the frame is dropped. `wrStrobe` stays low and no flag changes.
- R6: A `clrNewData` pulse clears both the new-data and the message-lost bit of that object. A `clrIntPend` pulse clears its interrupt-pending bit. A store to the same object in the same cycle takes priority over either clear.
- R7: A `setTxReq` pulse sets the transmit-request bit and a `txDone` pulse clears it. When both arrive in the same cycle, the set takes priority.
- R8: A `txDone` pulse on an object whose transmit-request bit is set also sets that object's interrupt-pending bit. A `txDone` pulse on an object with no request pending leaves interrupt-pending unchanged.
- R9: While `statusPend` is high, `intId` is 0x8000, whatever the object flags hold.
- R10: Otherwise `intId` is the object number (bit position + 1) of the lowest set interrupt-pending bit, or 0 when none is set.
- R11: A cycle with `frameValid` low produces no write: `wrStrobe` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Accepted frame is presented this cycle |
| frameId | input | FRAME_ID_W | Identifier of the presented frame |
| objValid | input | NUM_OBJ | Per-object valid configuration |
| objIsRx | input | NUM_OBJ | Per-object direction, 1 = receive |
| objEob | input | NUM_OBJ | Per-object end-of-buffer marker |
| clrNewData | input | NUM_OBJ | Clear new-data and message-lost pulses |
| clrIntPend | input | NUM_OBJ | Clear interrupt-pending pulses |
| setTxReq | input | NUM_OBJ | Transmit-request set pulses |
| txDone | input | NUM_OBJ | Transmit-complete pulses |
| statusPend | input | 1 | Status interrupt pending |
| wrStrobe | output | 1 | A frame is being written to `wrIndex` |
| wrIndex | output | IDX_W | Bit position of the chosen object |
| wrId | output | FRAME_ID_W | Identifier of the frame being written |
| wrLost | output | 1 | The write overwrote unread data |
| newDataVec | output | NUM_OBJ | New-data flags |
| intPendVec | output | NUM_OBJ | Interrupt-pending flags |
| msgLostVec | output | NUM_OBJ | Message-lost flags |
| txReqVec | output | NUM_OBJ | Transmit-request flags |
| intId | output | INT_ID_W | Interrupt identifier |

## Verification
The bench builds the block with `NUM_OBJ` = 8 and an 11-bit frame identifier. With these values, filling every receive object and reaching the overwrite and drop cases takes only a handful of frames. It also means random configurations often run out of free objects, and often place objects with and without end-of-buffer side by side. The interrupt identifier keeps its full 16-bit width, so the status code 0x8000 is checked exactly as in the default build.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;

  // Upper bound on the object index width carried between control and datapath
  localparam int MAX_IDX_W = 8;

  // Strobes from the allocation control to the flag datapath
  typedef struct packed {
    logic                 store;      // write a frame this cycle
    logic                 overwrite;  // target holds unread data
    logic [MAX_IDX_W-1:0] idx;        // target object bit position
  } allocStrobe_t;

endpackage

// File: rtl/rxfifo_lowest.sv
module rxfifo_lowest #(
  parameter int WIDTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Priority encoder: the lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int IDX_W   = 5
) (
  input  logic               frameValid,
  input  logic [NUM_OBJ-1:0] objValid,
  input  logic [NUM_OBJ-1:0] objIsRx,
  input  logic [NUM_OBJ-1:0] objEob,
  input  logic [NUM_OBJ-1:0] newDataVec,
  output allocStrobe_t       strobes
);

  logic [NUM_OBJ-1:0] freeVec;
  logic [NUM_OBJ-1:0] eobVec;
  logic               freeFound;
  logic               eobFound;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   eobIdx;

  assign freeVec = objValid & objIsRx & ~newDataVec;
  assign eobVec  = objValid & objIsRx & objEob;

  rxfifo_lowest #(.WIDTH(NUM_OBJ), .IDX_W(IDX_W)) freeEnc (
    .vec(freeVec), .found(freeFound), .idx(freeIdx)
  );

  rxfifo_lowest #(.WIDTH(NUM_OBJ), .IDX_W(IDX_W)) eobEnc (
    .vec(eobVec), .found(eobFound), .idx(eobIdx)
  );

  always_comb begin
    strobes.store     = frameValid && (freeFound || eobFound);
    strobes.overwrite = !freeFound && eobFound;
    strobes.idx       = freeFound ? MAX_IDX_W'(freeIdx) : MAX_IDX_W'(eobIdx);
  end

endmodule

// File: rtl/rxfifo_dp.sv
module rxfifo_dp
  import rxfifo_pkg::*;
#(
  parameter int NUM_OBJ    = 32,
  parameter int IDX_W      = 5,
  parameter int FRAME_ID_W = 29,
  parameter int INT_ID_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  allocStrobe_t          strobes,
  input  logic [FRAME_ID_W-1:0] frameId,
  input  logic [NUM_OBJ-1:0]    clrNewData,
  input  logic [NUM_OBJ-1:0]    clrIntPend,
  input  logic [NUM_OBJ-1:0]    setTxReq,
  input  logic [NUM_OBJ-1:0]    txDone,
  input  logic                  statusPend,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex,
  output logic [FRAME_ID_W-1:0] wrId,
  output logic                  wrLost,
  output logic [NUM_OBJ-1:0]    newDataVec,
  output logic [NUM_OBJ-1:0]    intPendVec,
  output logic [NUM_OBJ-1:0]    msgLostVec,
  output logic [NUM_OBJ-1:0]    txReqVec,
  output logic [INT_ID_W-1:0]   intId
);

  localparam logic [INT_ID_W-1:0] STATUS_CODE = {1'b1, {(INT_ID_W-1){1'b0}}};

  // Per-object flag cells
  for (genvar i = 0; i < NUM_OBJ; i++) begin : gObj
    logic hit;
    logic nd, ml, ip, tr;

    assign hit = strobes.store && (strobes.idx == MAX_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nd <= 1'b0;
        ml <= 1'b0;
        ip <= 1'b0;
        tr <= 1'b0;
      end else begin
        nd <= hit | (nd & ~clrNewData[i]);
        ml <= (hit & strobes.overwrite) | (ml & ~clrNewData[i]);
        ip <= hit | (txDone[i] & tr) | (ip & ~clrIntPend[i]);
        tr <= setTxReq[i] | (tr & ~txDone[i]);
      end
    end

    assign newDataVec[i] = nd;
    assign msgLostVec[i] = ml;
    assign intPendVec[i] = ip;
    assign txReqVec[i]   = tr;
  end

  // Write-side report registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrLost   <= 1'b0;
      wrIndex  <= '0;
      wrId     <= '0;
    end else begin
      wrStrobe <= strobes.store;
      wrLost   <= strobes.store & strobes.overwrite;
      if (strobes.store) begin
        wrIndex <= strobes.idx[IDX_W-1:0];
        wrId    <= frameId;
      end
    end
  end

  // Interrupt identifier: status first, then the lowest pending object
  logic             pendFound;
  logic [IDX_W-1:0] pendIdx;

  rxfifo_lowest #(.WIDTH(NUM_OBJ), .IDX_W(IDX_W)) pendEnc (
    .vec(intPendVec), .found(pendFound), .idx(pendIdx)
  );

  always_comb begin
    if (statusPend)     intId = STATUS_CODE;
    else if (pendFound) intId = INT_ID_W'(pendIdx) + INT_ID_W'(1);
    else                intId = '0;
  end

endmodule

// File: rtl/rxfifo_alloc.sv
module rxfifo_alloc
  import rxfifo_pkg::*;
#(
  parameter int NUM_OBJ    = 32,
  parameter int FRAME_ID_W = 29,
  parameter int INT_ID_W   = 16,
  localparam int IDX_W     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameValid,
  input  logic [FRAME_ID_W-1:0] frameId,
  input  logic [NUM_OBJ-1:0]    objValid,
  input  logic [NUM_OBJ-1:0]    objIsRx,
  input  logic [NUM_OBJ-1:0]    objEob,
  input  logic [NUM_OBJ-1:0]    clrNewData,
  input  logic [NUM_OBJ-1:0]    clrIntPend,
  input  logic [NUM_OBJ-1:0]    setTxReq,
  input  logic [NUM_OBJ-1:0]    txDone,
  input  logic                  statusPend,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex,
  output logic [FRAME_ID_W-1:0] wrId,
  output logic                  wrLost,
  output logic [NUM_OBJ-1:0]    newDataVec,
  output logic [NUM_OBJ-1:0]    intPendVec,
  output logic [NUM_OBJ-1:0]    msgLostVec,
  output logic [NUM_OBJ-1:0]    txReqVec,
  output logic [INT_ID_W-1:0]   intId
);

  allocStrobe_t strobes;

  rxfifo_ctrl #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) ctrl (
    .frameValid (frameValid),
    .objValid   (objValid),
    .objIsRx    (objIsRx),
    .objEob     (objEob),
    .newDataVec (newDataVec),
    .strobes    (strobes)
  );

  rxfifo_dp #(
    .NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W),
    .FRAME_ID_W(FRAME_ID_W), .INT_ID_W(INT_ID_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .frameId    (frameId),
    .clrNewData (clrNewData),
    .clrIntPend (clrIntPend),
    .setTxReq   (setTxReq),
    .txDone     (txDone),
    .statusPend (statusPend),
    .wrStrobe   (wrStrobe),
    .wrIndex    (wrIndex),
    .wrId       (wrId),
    .wrLost     (wrLost),
    .newDataVec (newDataVec),
    .intPendVec (intPendVec),
    .msgLostVec (msgLostVec),
    .txReqVec   (txReqVec),
    .intId      (intId)
  );

endmodule

// File: rtl/rxfifo_alloc_chk.sv
module rxfifo_alloc_chk #(
  parameter int NUM_OBJ  = 32,
  parameter int IDX_W    = 5,
  parameter int INT_ID_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameValid,
  input logic [NUM_OBJ-1:0]  objValid,
  input logic [NUM_OBJ-1:0]  objIsRx,
  input logic [NUM_OBJ-1:0]  objEob,
  input logic                statusPend,
  input logic                wrStrobe,
  input logic [IDX_W-1:0]    wrIndex,
  input logic                wrLost,
  input logic [NUM_OBJ-1:0]  newDataVec,
  input logic [NUM_OBJ-1:0]  intPendVec,
  input logic [NUM_OBJ-1:0]  msgLostVec,
  input logic [INT_ID_W-1:0] intId
);

  localparam logic [INT_ID_W-1:0] STATUS_CODE = {1'b1, {(INT_ID_W-1){1'b0}}};

  logic anyFree;
  logic anyEob;
  assign anyFree = |(objValid & objIsRx & ~newDataVec);
  assign anyEob  = |(objValid & objIsRx & objEob);

  // R11
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !wrStrobe);

  // R2
  free_slot_used_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && anyFree) |=> (wrStrobe && !wrLost));

  // R3
  store_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (newDataVec[wrIndex] && intPendVec[wrIndex]));

  // R3
  single_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(newDataVec & ~$past(newDataVec)));

  // R4
  lost_marked_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLost |-> (wrStrobe && msgLostVec[wrIndex]));

  // R5
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !anyFree && !anyEob) |=> !wrStrobe);

  // R9
  status_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusPend |-> (intId == STATUS_CODE));

  // R10
  idle_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusPend && (intPendVec == '0)) |-> (intId == '0));

endmodule

bind rxfifo_alloc rxfifo_alloc_chk #(
  .NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .INT_ID_W(INT_ID_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .objValid   (objValid),
  .objIsRx    (objIsRx),
  .objEob     (objEob),
  .statusPend (statusPend),
  .wrStrobe   (wrStrobe),
  .wrIndex    (wrIndex),
  .wrLost     (wrLost),
  .newDataVec (newDataVec),
  .intPendVec (intPendVec),
  .msgLostVec (msgLostVec),
  .intId      (intId)
);

// File: tb/rxfifo_alloc_test.sv
module rxfifo_alloc_test;

  localparam int N  = 8;
  localparam int FW = 11;
  localparam int IW = 3;
  localparam int XW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameValid = 1'b0;
  logic [FW-1:0] frameId = '0;
  logic [N-1:0]  objValid = '0, objIsRx = '0, objEob = '0;
  logic [N-1:0]  clrNewData = '0, clrIntPend = '0, setTxReq = '0, txDone = '0;
  logic          statusPend = 1'b0;
  logic          wrStrobe, wrLost;
  logic [IW-1:0] wrIndex;
  logic [FW-1:0] wrId;
  logic [N-1:0]  newDataVec, intPendVec, msgLostVec, txReqVec;
  logic [XW-1:0] intId;

  always #10 clk = ~clk;  // 50 MHz

  rxfifo_alloc #(.NUM_OBJ(N), .FRAME_ID_W(FW), .INT_ID_W(XW)) uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameId(frameId),
    .objValid(objValid), .objIsRx(objIsRx), .objEob(objEob),
    .clrNewData(clrNewData), .clrIntPend(clrIntPend),
    .setTxReq(setTxReq), .txDone(txDone), .statusPend(statusPend),
    .wrStrobe(wrStrobe), .wrIndex(wrIndex), .wrId(wrId), .wrLost(wrLost),
    .newDataVec(newDataVec), .intPendVec(intPendVec),
    .msgLostVec(msgLostVec), .txReqVec(txReqVec), .intId(intId)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state (value after the most recent edge)
  logic [N-1:0]  mNd = '0, mIp = '0, mMl = '0, mTx = '0;
  logic          mStr = 0, mLost = 0;
  int            mIdx = 0;
  logic [FW-1:0] mId = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expIntId();
    if (statusPend) return 32'h8000;
    for (int i = 0; i < N; i++) if (mIp[i]) return 32'(i + 1);
    return 32'h0;
  endfunction

  // Behavioural prediction of the next edge
  task automatic modelStep();
    int sel;
    bit ovr;
    sel = -1;
    ovr = 0;
    if (!rstN) begin
      mNd = '0; mIp = '0; mMl = '0; mTx = '0; mStr = 0; mLost = 0;
      return;
    end
    for (int i = 0; i < N; i++)
      if (sel < 0 && objValid[i] && objIsRx[i] && !mNd[i]) sel = i;
    if (sel < 0)
      for (int i = 0; i < N; i++)
        if (sel < 0 && objValid[i] && objIsRx[i] && objEob[i]) begin
          sel = i;
          ovr = 1;
        end
    if (!frameValid) sel = -1;
    mNd = mNd & ~clrNewData;
    mMl = mMl & ~clrNewData;
    mIp = (mIp & ~clrIntPend) | (txDone & mTx);
    mTx = (mTx & ~txDone) | setTxReq;
    mStr = (sel >= 0);
    mLost = mStr && ovr;
    if (mStr) begin
      mNd[sel] = 1'b1;
      mIp[sel] = 1'b1;
      if (ovr) mMl[sel] = 1'b1;
      mIdx = sel;
      mId = frameId;
    end
  endtask

  task automatic compareAll();
    chk("R2/R11 wrStrobe", 32'(wrStrobe), 32'(mStr));
    if (mStr) begin
      chk("R2 wrIndex", 32'(wrIndex), 32'(mIdx));
      chk("R2 wrId", 32'(wrId), 32'(mId));
    end
    chk("R4 wrLost", 32'(wrLost), 32'(mLost));
    chk("R3 newData", 32'(newDataVec), 32'(mNd));
    chk("R8 intPend", 32'(intPendVec), 32'(mIp));
    chk("R4 msgLost", 32'(msgLostVec), 32'(mMl));
    chk("R7 txReq", 32'(txReqVec), 32'(mTx));
    chk("R10 intId", 32'(intId), expIntId());
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    frameValid = 0;
    clrNewData = '0; clrIntPend = '0; setTxReq = '0; txDone = '0;
  endtask

  task automatic sendFrame(logic [FW-1:0] id);
    frameValid = 1;
    frameId = id;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual 150000 cycles expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    // R1: reset state while held
    chk("R1 reset wrStrobe", 32'(wrStrobe), 0);
    chk("R1 reset intId", 32'(intId), 0);
    chk("R1 reset flags", 32'({newDataVec, intPendVec, msgLostVec, txReqVec}), 0);
    rstN = 1;
    tick();
    chk("R1 after release flags", 32'({newDataVec, intPendVec, msgLostVec, txReqVec}), 0);

    // Objects 0..3 receive FIFO ending at 3, 4..7 transmit
    objValid = 8'hFF; objIsRx = 8'h0F; objEob = 8'h08;
    tick();
    chk("R11 idle no write", 32'(wrStrobe), 0);

    for (int k = 0; k < 4; k++) begin
      sendFrame(FW'(11'h100 + k));
      chk("R2 lowest free index", 32'(wrIndex), 32'(k));
    end
    sendFrame(11'h7AA);
    chk("R4 overwrite flag", 32'(wrLost), 1);
    chk("R4 overwrite index", 32'(wrIndex), 3);
    chk("R4 msgLost bit", 32'(msgLostVec), 32'h08);

    clrNewData = 8'h02;
    tick();
    chk("R6 clear new-data", 32'(newDataVec), 32'h0D);
    sendFrame(11'h055);
    chk("R2 gap refilled", 32'(wrIndex), 1);

    clrNewData = 8'h0F;
    tick();
    chk("R6 clear drops msgLost", 32'(msgLostVec), 0);
    objValid = 8'hFE;
    sendFrame(11'h066);
    chk("R2 invalid object skipped", 32'(wrIndex), 1);
    objValid = 8'hFF;

    // No end-of-buffer: full FIFO drops
    objEob = 8'h00;
    sendFrame(11'h001);
    sendFrame(11'h002);
    sendFrame(11'h003);
    chk("R2 fill last", 32'(wrIndex), 3);
    sendFrame(11'h004);
    chk("R5 dropped no strobe", 32'(wrStrobe), 0);
    chk("R5 dropped flags", 32'(newDataVec), 32'h0F);

    clrNewData = 8'hFF; clrIntPend = 8'hFF;
    tick();
    chk("R10 nothing pending", 32'(intId), 0);
    clrIntPend = 8'h01;
    sendFrame(11'h0AB);
    chk("R6 store beats clear", 32'(intPendVec), 32'h01);
    chk("R10 single pending", 32'(intId), 1);
    clrIntPend = 8'h01; clrNewData = 8'h01;
    tick();

    // Transmit requests
    setTxReq = 8'h30;
    tick();
    chk("R7 set", 32'(txReqVec), 32'h30);
    setTxReq = 8'h20; txDone = 8'h20;
    tick();
    chk("R7 set beats done", 32'(txReqVec), 32'h30);
    chk("R8 done raises pending", 32'(intPendVec), 32'h20);
    txDone = 8'h10;
    tick();
    chk("R7 done clears", 32'(txReqVec), 32'h20);
    chk("R10 lowest pending", 32'(intId), 5);
    txDone = 8'h04;
    tick();
    chk("R8 done without request", 32'(intPendVec), 32'h30);

    statusPend = 1;
    tick();
    chk("R9 status code", 32'(intId), 32'h8000);
    statusPend = 0;
    clrIntPend = 8'hFF;
    tick();

    // Random traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) begin
        objValid = N'($urandom);
        objIsRx  = N'($urandom);
        objEob   = N'($urandom) & N'($urandom);
      end
      frameValid = ($urandom % 3) != 0;
      frameId    = FW'($urandom);
      clrNewData = (($urandom % 4) == 0) ? N'($urandom) : '0;
      clrIntPend = (($urandom % 4) == 0) ? N'($urandom) : '0;
      setTxReq   = (($urandom % 5) == 0) ? N'($urandom) : '0;
      txDone     = (($urandom % 5) == 0) ? N'($urandom) : '0;
      statusPend = ($urandom % 8) == 0;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule